// File: doc/BRIEF.md
# Display Engine Clock and Reset Controller

This block gives software control over the clocking and reset of four display sub-units: mixer 0, mixer 1, a write-back unit and a rotate unit. A small 32-bit register bus sets three groups of per-unit bits: module clock gates, bus clock enables and bus resets. It also sets a 4-bit divider for each unit and one routing bit. The routing bit swaps which mixer drives each of the two timing-controller outputs.

Each divided module clock is modelled as a one-cycle enable strobe in the source clock domain. No clock-tree cells are used. A build option ties mixer 1's bus reset to the write-back reset bit. In that mode, mixer 1's own reset bit has no effect.

All register bits are zero after reset. Every unit therefore starts with its clocks off, held in bus reset, with its divider at ratio 1 and with the direct routing selected.

Top module: `dispctl_clkrst`

## Requirements
- R1: After `rst_n` is released, every output is 0 and every register reads back 0.
- R2: Bits [3:0] of the word at byte offset 0x00 are the module clock gates, ordered mixer 0, mixer 1, write-back, rotate from bit 0 up. `mod_clk_en` shows a written value in the cycle after the write edge.
- R3: Bits [3:0] of the word at offset 0x04 drive `bus_clk_en`, with the same unit order and the same one-cycle timing.
- R4: Bits [3:0] of the word at offset 0x08 drive the active-low `bus_rst_n`, with the same unit order. A unit stays in reset until a 1 is written to its bit.
- R5: The word at offset 0x0C holds four 4-bit divider fields. Unit i uses bits [4i+3:4i]. While a unit's gate is set, its strobe is high for one cycle in every field+1 cycles, so a field of 0 gives a strobe every cycle.
- R6: A write to offset 0x0C, or a clear module gate, restarts a unit's divider count at 0. The first strobe then falls field cycles after the write edge that set the gate or the divider. While the gate is clear, the unit gives no strobe.
- R7: Bit 0 of the word at offset 0x10 drives `route_swap`. A value of 0 routes mixer 0 to timing controller 0 and mixer 1 to timing controller 1. A value of 1 crosses the two.
- R8: Bits above each register's defined field read 0, and writes to them have no effect. Addresses 0x14 to 0x1C read 0.
- R9: With `SHARE_WB_RST` = 1, write-back reset bit 2 drives both `bus_rst_n[2]` and `bus_rst_n[1]`, and bit 1 has no effect. With the default of 0, each bit drives only its own unit.
- R10: `reg_rdata` is loaded at the clock edge on which `reg_rd` is high. Between reads it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 5 | Byte address, word aligned |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| mod_clk_en | output | 4 | Module clock gate per unit |
| bus_clk_en | output | 4 | Bus clock enable per unit |
| bus_rst_n | output | 4 | Active-low bus reset per unit |
| div_strobe | output | 4 | Divided-clock strobe per unit |
| route_swap | output | 1 | Mixer-to-timing-controller crossing |

## Verification
Gate, enable, reset and routing outputs take a written value one edge after the write. The bench therefore samples them 1 ns after the edge that carried the write. Read data also appears one edge after `reg_rd`, and the bench samples it at the same point.

Divider strobes depend on the counter state during a cycle. The bench counts cycles from the write edge that restarted the divider and records the cycle index of the first two strobes. It expects the first at index field and the second at index 2·field+1. A second instance built with the shared reset option runs on the same bus, so both reset mappings are compared on every write.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
  localparam int UNITS  = 4;
  localparam int DIV_W  = 4;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 32;

  typedef enum logic [2:0] {
    SEL_GATE, SEL_BUSG, SEL_RST, SEL_DIV, SEL_ROUTE, SEL_NONE
  } reg_sel_e;

  function automatic reg_sel_e addr_decode(input logic [ADDR_W-1:0] a);
    case (a)
      5'h00:   return SEL_GATE;
      5'h04:   return SEL_BUSG;
      5'h08:   return SEL_RST;
      5'h0C:   return SEL_DIV;
      5'h10:   return SEL_ROUTE;
      default: return SEL_NONE;
    endcase
  endfunction

  function automatic logic [DIV_W-1:0] div_field(
      input logic [UNITS*DIV_W-1:0] packed_v, input int idx);
    return packed_v[idx*DIV_W +: DIV_W];
  endfunction
endpackage

// File: rtl/dcr_regs.sv
module dcr_regs
  import dcr_pkg::*;
#(
  parameter int N_UNIT = UNITS,
  parameter int DW     = DIV_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr,
  input  logic                   rd,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W-1:0]      wdata,
  output logic [DATA_W-1:0]      rdata,
  output logic [N_UNIT-1:0]      gate_q,
  output logic [N_UNIT-1:0]      busg_q,
  output logic [N_UNIT-1:0]      rstb_q,
  output logic [N_UNIT*DW-1:0]   div_q,
  output logic                   route_q,
  output logic                   div_wr
);
  localparam int DIVS_W = N_UNIT * DW;

  reg_sel_e          sel;
  logic [DATA_W-1:0] rd_mux;

  assign sel    = addr_decode(addr);
  assign div_wr = wr && (sel == SEL_DIV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q  <= '0;
      busg_q  <= '0;
      rstb_q  <= '0;
      div_q   <= '0;
      route_q <= 1'b0;
    end else if (wr) begin
      case (sel)
        SEL_GATE:  gate_q  <= wdata[N_UNIT-1:0];
        SEL_BUSG:  busg_q  <= wdata[N_UNIT-1:0];
        SEL_RST:   rstb_q  <= wdata[N_UNIT-1:0];
        SEL_DIV:   div_q   <= wdata[DIVS_W-1:0];
        SEL_ROUTE: route_q <= wdata[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_GATE:  rd_mux[N_UNIT-1:0] = gate_q;
      SEL_BUSG:  rd_mux[N_UNIT-1:0] = busg_q;
      SEL_RST:   rd_mux[N_UNIT-1:0] = rstb_q;
      SEL_DIV:   rd_mux[DIVS_W-1:0] = div_q;
      SEL_ROUTE: rd_mux[0]          = route_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= rd_mux;
  end

  // R2
  gate_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == SEL_GATE) |=> (gate_q == $past(wdata[N_UNIT-1:0])));

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata));

  // R8
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[DATA_W-1:DIVS_W] == '0);
endmodule

// File: rtl/dcr_div.sv
module dcr_div #(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gate,
  input  logic [DW-1:0] ratio_m1,
  input  logic          restart,
  output logic          strobe
);
  logic [DW-1:0] cnt_q;
  logic          wrap;
  logic          clear;

  assign wrap   = (cnt_q == ratio_m1);
  assign clear  = restart || !gate;
  assign strobe = gate && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clear)   cnt_q <= '0;
    else if (wrap)    cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= ratio_m1);

  // R5
  strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && ratio_m1 != '0 && !restart) |=> !strobe);

  // R6
  gate_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gate |=> (cnt_q == '0));
endmodule

// File: rtl/dcr_rst_map.sv
module dcr_rst_map #(
  parameter int N_UNIT   = 4,
  parameter bit SHARE_EN = 1'b0,
  parameter int SRC_IDX  = 2,
  parameter int DST_IDX  = 1
) (
  input  logic [N_UNIT-1:0] rst_bits,
  output logic [N_UNIT-1:0] rst_out_n
);
  generate
    for (genvar u = 0; u < N_UNIT; u++) begin : g_unit
      if (SHARE_EN && u == DST_IDX) begin : g_shared
        assign rst_out_n[u] = rst_bits[SRC_IDX];
      end else begin : g_own
        assign rst_out_n[u] = rst_bits[u];
      end
    end
  endgenerate
endmodule

// File: rtl/dispctl_clkrst.sv
module dispctl_clkrst
  import dcr_pkg::*;
#(
  parameter int N_UNIT       = UNITS,
  parameter int DW           = DIV_W,
  parameter bit SHARE_WB_RST = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [4:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [N_UNIT-1:0] mod_clk_en,
  output logic [N_UNIT-1:0] bus_clk_en,
  output logic [N_UNIT-1:0] bus_rst_n,
  output logic [N_UNIT-1:0] div_strobe,
  output logic              route_swap
);
  localparam int WB_IDX = 2;
  localparam int M1_IDX = 1;

  logic [N_UNIT-1:0]    gate_q;
  logic [N_UNIT-1:0]    rstb_q;
  logic [N_UNIT*DW-1:0] div_q;
  logic                 div_wr;

  dcr_regs #(.N_UNIT(N_UNIT), .DW(DW)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (reg_wr),
    .rd     (reg_rd),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .rdata  (reg_rdata),
    .gate_q (gate_q),
    .busg_q (bus_clk_en),
    .rstb_q (rstb_q),
    .div_q  (div_q),
    .route_q(route_swap),
    .div_wr (div_wr)
  );

  assign mod_clk_en = gate_q;

  generate
    for (genvar u = 0; u < N_UNIT; u++) begin : g_div
      dcr_div #(.DW(DW)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .gate    (gate_q[u]),
        .ratio_m1(div_field(div_q, u)),
        .restart (div_wr),
        .strobe  (div_strobe[u])
      );
    end
  endgenerate

  dcr_rst_map #(
    .N_UNIT(N_UNIT), .SHARE_EN(SHARE_WB_RST),
    .SRC_IDX(WB_IDX), .DST_IDX(M1_IDX)
  ) u_rst_map (
    .rst_bits (rstb_q),
    .rst_out_n(bus_rst_n)
  );

  logic rst_wr;
  assign rst_wr = reg_wr && (addr_decode(reg_addr) == SEL_RST);

  // R4
  wb_rst_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_wr |=> (bus_rst_n[WB_IDX] == $past(reg_wdata[WB_IDX])));

  // R9
  m1_rst_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_wr |=> (bus_rst_n[M1_IDX] ==
                $past(SHARE_WB_RST ? reg_wdata[WB_IDX] : reg_wdata[M1_IDX])));

  // R7
  route_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && addr_decode(reg_addr) == SEL_ROUTE) |=> (route_swap == $past(reg_wdata[0])));
endmodule

// File: tb/test_dispctl_clkrst.sv
`timescale 1ns/1ps
module test_dispctl_clkrst;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr = 1'b0, rd = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata_s;
  logic [3:0]  gate, busg, rstn, stb, gate_s, busg_s, rstn_s, stb_s;
  logic        route, route_s;
  int checks = 0, errors = 0;
  logic [31:0] m [5];

  always #2.5 clk = ~clk;

  dispctl_clkrst i_dispctl_clkrst (
    .clk(clk), .rst_n(rst_n), .reg_wr(wr), .reg_rd(rd), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .mod_clk_en(gate), .bus_clk_en(busg),
    .bus_rst_n(rstn), .div_strobe(stb), .route_swap(route));

  dispctl_clkrst #(.SHARE_WB_RST(1'b1)) i_dispctl_clkrst_sh (
    .clk(clk), .rst_n(rst_n), .reg_wr(wr), .reg_rd(rd), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata_s), .mod_clk_en(gate_s), .bus_clk_en(busg_s),
    .bus_rst_n(rstn_s), .div_strobe(stb_s), .route_swap(route_s));

  function automatic int exp_period(input int field);
    return field + 1;
  endfunction

  function automatic logic [31:0] reg_mask(input logic [4:0] a);
    case (a)
      5'h00, 5'h04, 5'h08: return 32'hF;
      5'h0C:               return 32'hFFFF;
      5'h10:               return 32'h1;
      default:             return 32'h0;
    endcase
  endfunction

  function automatic logic [3:0] shared_rst(input logic [3:0] bits);
    return {bits[3], bits[2], bits[2], bits[0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1; wr = 1'b0;
    if (a <= 5'h10 && a[1:0] == 2'b00) m[a >> 2] = d & reg_mask(a);
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    @(posedge clk); #1; rd = 1'b0; d = rdata;
  endtask

  function automatic logic [31:0] model_rd(input logic [4:0] a);
    if (a <= 5'h10 && a[1:0] == 2'b00) return m[a >> 2];
    return 32'h0;
  endfunction

  task automatic measure(input int n);
    logic [15:0] val;
    int first [4], second [4];
    for (int u = 0; u < 4; u++) begin
      val[u*4 +: 4] = 4'((n + u) % 16);
      first[u] = -1; second[u] = -1;
    end
    bus_wr(5'h0C, {16'hABCD, val});
    for (int k = 0; k < 40; k++) begin
      for (int u = 0; u < 4; u++)
        if (stb[u]) begin
          if (first[u] < 0) first[u] = k;
          else if (second[u] < 0) second[u] = k;
        end
      @(posedge clk); #1;
    end
    for (int u = 0; u < 4; u++) begin
      chk("R6 first strobe", first[u], (n + u) % 16);
      chk("R5 strobe period", second[u] - first[u], exp_period((n + u) % 16));
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog R1 actual timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int cnt [4];
    void'($urandom(32'd1234));
    for (int i = 0; i < 5; i++) m[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    // R1 reset state
    chk("R1 outputs", {gate, busg, rstn, stb, route}, 32'h0);
    for (int i = 0; i < 5; i++) begin
      bus_rd(5'(i * 4), d);
      chk("R1 readback", d, 32'h0);
    end

    // R2 / R3 gates
    bus_wr(5'h00, 32'hFFFF_FFF5);
    chk("R2 mod gate", gate, 4'h5);
    bus_wr(5'h04, 32'h0000_000A);
    chk("R3 bus gate", busg, 4'hA);

    // R5 / R6 all divider values
    bus_wr(5'h00, 32'hF);
    for (int n = 0; n < 16; n++) measure(n);

    // R6 gate off: no strobes on unit 2
    bus_wr(5'h00, 32'hB);
    bus_wr(5'h0C, 32'h0);
    for (int u = 0; u < 4; u++) cnt[u] = 0;
    for (int k = 0; k < 10; k++) begin
      for (int u = 0; u < 4; u++) if (stb[u]) cnt[u]++;
      @(posedge clk); #1;
    end
    chk("R6 gated unit silent", cnt[2], 0);
    chk("R5 ratio one unit0", cnt[0], 10);
    // R6 restart on gate set
    bus_wr(5'h0C, 32'h0300);
    for (int u = 0; u < 4; u++) cnt[u] = -1;
    bus_wr(5'h00, 32'hF);
    for (int k = 0; k < 8; k++) begin
      if (stb[2] && cnt[2] < 0) cnt[2] = k;
      @(posedge clk); #1;
    end
    chk("R6 first after gate", cnt[2], 3);

    // R4 / R9 resets
    chk("R4 held in reset", rstn, 4'h0);
    bus_wr(5'h08, 32'h4);
    chk("R4 wb released", rstn, 4'h4);
    chk("R9 shared m1 follows wb", rstn_s, 4'h6);
    bus_wr(5'h08, 32'h2);
    chk("R9 own m1 bit", rstn, 4'h2);
    chk("R9 shared m1 bit ignored", rstn_s, 4'h0);
    bus_wr(5'h08, 32'hFFFF_FFF9);
    chk("R4 mixed", rstn, 4'h9);

    // R7 routing
    bus_wr(5'h10, 32'h1);
    chk("R7 swap", route, 1'b1);
    bus_wr(5'h10, 32'hFFFF_FFFE);
    chk("R7 direct", route, 1'b0);
    bus_rd(5'h10, d);
    chk("R8 route upper bits", d, 32'h0);

    // R10 hold between reads
    bus_rd(5'h08, d);
    bus_wr(5'h08, 32'h0);
    @(posedge clk); #1;
    chk("R10 rdata held", rdata, 32'h9);

    // R8 random writes and readback
    for (int i = 0; i < 200; i++) begin
      logic [4:0] a;
      a = 5'(($urandom % 8) * 4);
      bus_wr(a, $urandom);
      bus_rd(a, d);
      chk("R8 readback", d, model_rd(a));
      chk("R2 gate out", gate, m[0][3:0]);
      chk("R3 bus out", busg, m[1][3:0]);
      chk("R4 rst out", rstn, m[2][3:0]);
      chk("R9 shared rst", rstn_s, shared_rst(m[2][3:0]));
      chk("R7 route out", route, m[4][0]);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule